// File: doc/BRIEF.md
# Gated General-Purpose Input Port

This block samples a group of external input pins into one read-only 32-bit status word that software reads over a simple register port. Every pin has a matching bit in an enable vector supplied on its own input. Only an enabled pin is captured; a pin whose enable bit is 0 reads as 0, and any activity on it is ignored. Lowering an enable bit clears the stored copy of that pin at the next clock edge.

Each pin first passes through a synchronizer chain, two flops deep by default. The synchronized level, gated by the enable vector, is then stored. If any stored bit goes from 0 to 1, the block raises a one-cycle interrupt pulse in the same cycle that the new value appears. This also covers a pin that is already high when its enable bit is set. A falling bit never raises the pulse.

The pin count `NUM_PINS` can be set from 0 to 32. A larger value stops elaboration with an error. Bits at and above `NUM_PINS` always read as 0.

Top module: `gated_gpi`

## Requirements
- R1: While `rst_n` is low at a rising edge, the stored word, `irq_o` and `bus_rdata_o` are all 0 after that edge. A read after reset, with all pins low, returns 0.
- R2: With its enable bit held at 1, a pin's level shows in the stored word at the third rising edge after the pin changes: two synchronizer stages and then the storage flop. Bit i of the word is pin i, and the word is little-endian on the port.
- R3: A pin whose enable bit is 0 reads as 0 whatever its level, and toggling it raises no interrupt.
- R4: When an enable bit goes from 1 to 0, the stored bit is 0 from the first rising edge that samples the new enable value. This holds even while the pin stays high, and the clear raises no interrupt.
- R5: When any stored bit goes from 0 to 1, `irq_o` is high for the single cycle that follows that edge. This includes setting the enable bit of a pin that is already high.
- R6: A stored bit that goes from 1 to 0 raises no interrupt.
- R7: Several bits rising at the same edge produce exactly one pulse, one clock wide.
- R8: Writes (`bus_we_i` = 1) never change the stored word, and during a write `bus_rdata_o` stays 0 in the following cycle.
- R9: A read is a cycle with `bus_en_i` = 1, `bus_we_i` = 0, byte address 0 and all four byte enables set (4'hF). The cycle after a read, `bus_rdata_o` holds the stored word zero-extended from `NUM_PINS` bits. Every other cycle, including a read at another address or with partial byte enables, leaves `bus_rdata_o` at 0. Pins at index `NUM_PINS` and above are never seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| gpi_pins_i | input | 32 | Raw asynchronous input pins; bits at and above NUM_PINS are unused |
| gpi_en_i | input | 32 | Per-pin capture enable, 1 = pin is sampled |
| bus_en_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | 1 = write (ignored), 0 = read |
| bus_addr_i | input | ADDR_W | Byte address of the access |
| bus_be_i | input | 4 | Byte enables; a valid access sets all four |
| bus_wdata_i | input | 32 | Write data, discarded |
| bus_rdata_o | output | 32 | Read data, valid the cycle after a read, else 0 |
| irq_o | output | 1 | One-cycle pulse on any 0-to-1 stored transition |

## Verification
The assertions watch every cycle for the following: no stored bit outside the enable vector of the previous edge, an interrupt pulse exactly when some stored bit rose, no pulse without a rise, read data that is either the stored word from one cycle earlier or zero, and nothing above the pin count. Other behaviour depends on how the stimulus is ordered, so only the directed scenarios can show it. This covers the three-edge synchronizer latency, the clear caused by lowering an enable, the pulse on re-enabling a high pin, the merging of simultaneous rises into one pulse, and the fact that writes leave the word untouched.

// File: rtl/gated_gpi_pkg.sv
// Package: shared widths and helpers for the gated input port.
// Assumes a 32-bit register port with byte enables.
package gated_gpi_pkg;
    localparam int unsigned REG_W     = 32;
    localparam int unsigned BE_W      = REG_W / 8;
    localparam int unsigned PIN_LIMIT = 32;

    // Mask with the low n bits set, used to bound the visible pins.
    function automatic logic [REG_W-1:0] low_mask(input int unsigned n);
        logic [REG_W-1:0] m;
        m = '0;
        for (int unsigned i = 0; i < REG_W; i++) begin
            if (i < n) m[i] = 1'b1;
        end
        return m;
    endfunction
endpackage

// File: rtl/gated_gpi_sync.sv
// Module: multi-stage synchronizer for a vector of asynchronous pins.
// Assumes STAGES >= 2; every stage is cleared by the synchronous reset.
module gated_gpi_sync #(
    parameter int unsigned WIDTH  = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    if (STAGES < 2) begin : g_bad_depth
        $error("gated_gpi_sync: STAGES must be at least 2");
    end

    // Shift the pin levels one stage deeper each cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q[0] <= d_i;
            for (int unsigned s = 1; s < STAGES; s++) begin
                chain_q[s] <= chain_q[s-1];
            end
        end
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/gated_gpi_capture.sv
// Module: enable-gated storage of synchronized pins plus rise detection.
// Assumes sync_i is already in the clk domain; en_i takes effect at the
// same edge it is sampled, so a dropped enable clears its bit at once.
module gated_gpi_capture #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] sync_i,
    input  logic [WIDTH-1:0] en_i,
    output logic [WIDTH-1:0] level_o,
    output logic             rise_o
);
    logic [WIDTH-1:0] level_q;
    logic [WIDTH-1:0] level_nxt;
    logic [WIDTH-1:0] bit_rise;

    // Per pin: gated next value and its 0-to-1 indication.
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        assign level_nxt[b] = en_i[b] & sync_i[b];
        assign bit_rise[b]  = level_nxt[b] & ~level_q[b];
    end

    // Store the gated levels; disabled pins settle to 0.
    always_ff @(posedge clk) begin
        if (!rst_n) level_q <= '0;
        else        level_q <= level_nxt;
    end

    assign level_o = level_q;
    assign rise_o  = |bit_rise;
endmodule

// File: rtl/gated_gpi_irq.sv
// Module: turns the combined rise indication into a registered pulse.
// Assumes rise_i is evaluated against the edge that updates storage,
// so the pulse lines up with the new stored value.
module gated_gpi_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic rise_i,
    output logic irq_o
);
    logic irq_q;

    // One registered pulse per edge on which any stored bit rises.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= rise_i;
    end

    assign irq_o = irq_q;
endmodule

// File: rtl/gated_gpi_regport.sv
// Module: read-only register window holding the stored pin word.
// Assumes only full-word accesses at byte offset 0 are valid; writes
// and all other accesses return zero on the following cycle.
module gated_gpi_regport
    import gated_gpi_pkg::*;
#(
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en_i,
    input  logic              bus_we_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [BE_W-1:0]   bus_be_i,
    input  logic [REG_W-1:0]  bus_wdata_i,
    input  logic [REG_W-1:0]  level_i,
    output logic [REG_W-1:0]  bus_rdata_o
);
    logic             rd_hit;
    logic [REG_W-1:0] rdata_q;
    logic             unused_wdata;

    assign rd_hit       = bus_en_i && !bus_we_i && (bus_addr_i == '0) && (bus_be_i == '1);
    assign unused_wdata = ^bus_wdata_i;

    // Return the stored word for a valid read, zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)      rdata_q <= '0;
        else if (rd_hit) rdata_q <= level_i;
        else             rdata_q <= '0;
    end

    assign bus_rdata_o = rdata_q;
endmodule

// File: rtl/gated_gpi.sv
// Module: gated general-purpose input port (top).
// Synchronizes NUM_PINS pins, stores those whose enable bit is set,
// pulses irq_o on any stored rise and exposes the word for reading.
// Assumes NUM_PINS <= 32; larger values stop elaboration.
module gated_gpi
    import gated_gpi_pkg::*;
#(
    parameter int unsigned NUM_PINS    = 32,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned ADDR_W      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_W-1:0]  gpi_pins_i,
    input  logic [REG_W-1:0]  gpi_en_i,
    input  logic              bus_en_i,
    input  logic              bus_we_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [BE_W-1:0]   bus_be_i,
    input  logic [REG_W-1:0]  bus_wdata_i,
    output logic [REG_W-1:0]  bus_rdata_o,
    output logic              irq_o
);
    logic [REG_W-1:0] level_vec;
    logic             rise_any;
    logic             unused_inputs;

    assign unused_inputs = ^{gpi_pins_i, gpi_en_i};

    if (NUM_PINS > PIN_LIMIT) begin : g_too_many
        $error("gated_gpi: NUM_PINS exceeds 32");
    end

    if (NUM_PINS > 0) begin : g_pins
        logic [NUM_PINS-1:0] sync_w;
        logic [NUM_PINS-1:0] level_w;

        gated_gpi_sync #(
            .WIDTH  (NUM_PINS),
            .STAGES (SYNC_STAGES)
        ) i_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d_i   (gpi_pins_i[NUM_PINS-1:0]),
            .q_o   (sync_w)
        );

        gated_gpi_capture #(
            .WIDTH (NUM_PINS)
        ) i_capture (
            .clk     (clk),
            .rst_n   (rst_n),
            .sync_i  (sync_w),
            .en_i    (gpi_en_i[NUM_PINS-1:0]),
            .level_o (level_w),
            .rise_o  (rise_any)
        );

        assign level_vec = REG_W'(level_w);
    end else begin : g_no_pins
        assign level_vec = '0;
        assign rise_any  = 1'b0;
    end

    gated_gpi_irq i_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .rise_i (rise_any),
        .irq_o  (irq_o)
    );

    gated_gpi_regport #(
        .ADDR_W (ADDR_W)
    ) i_regport (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_en_i    (bus_en_i),
        .bus_we_i    (bus_we_i),
        .bus_addr_i  (bus_addr_i),
        .bus_be_i    (bus_be_i),
        .bus_wdata_i (bus_wdata_i),
        .level_i     (level_vec),
        .bus_rdata_o (bus_rdata_o)
    );
endmodule

// File: rtl/gated_gpi_chk.sv
// Module: protocol checker bound to gated_gpi.
// Observes ports and the stored word; drives nothing.
module gated_gpi_chk
    import gated_gpi_pkg::*;
#(
    parameter int unsigned NUM_PINS = 32,
    parameter int unsigned ADDR_W   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [REG_W-1:0]  gpi_en_i,
    input logic              bus_en_i,
    input logic              bus_we_i,
    input logic [ADDR_W-1:0] bus_addr_i,
    input logic [BE_W-1:0]   bus_be_i,
    input logic [REG_W-1:0]  bus_rdata_o,
    input logic              irq_o,
    input logic [REG_W-1:0]  level_vec
);
    logic read_req;
    assign read_req = bus_en_i && !bus_we_i && (bus_addr_i == '0) && (bus_be_i == '1);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (level_vec == '0 && !irq_o && bus_rdata_o == '0));

    // R3 R4
    masked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((level_vec & ~$past(gpi_en_i)) == '0));

    // R5
    irq_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ((level_vec & ~$past(level_vec)) != '0));

    // R6
    no_irq_without_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((level_vec & ~$past(level_vec)) == '0) |-> !irq_o);

    // R9
    read_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        read_req |=> (bus_rdata_o == $past(level_vec)));

    // R8
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !read_req |=> (bus_rdata_o == '0));

    // R9
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> ((bus_rdata_o & ~low_mask(NUM_PINS)) == '0));
endmodule

bind gated_gpi gated_gpi_chk #(
    .NUM_PINS (NUM_PINS),
    .ADDR_W   (ADDR_W)
) i_gated_gpi_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .gpi_en_i    (gpi_en_i),
    .bus_en_i    (bus_en_i),
    .bus_we_i    (bus_we_i),
    .bus_addr_i  (bus_addr_i),
    .bus_be_i    (bus_be_i),
    .bus_rdata_o (bus_rdata_o),
    .irq_o       (irq_o),
    .level_vec   (level_vec)
);

// File: tb/test_gated_gpi.sv
// Directed bench for gated_gpi built with 24 pins; one task per scenario.
module test_gated_gpi;
    localparam int unsigned PINS  = 24;
    localparam logic [31:0] VMASK = 32'h00FF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] pins;
    logic [31:0] en;
    logic        bus_en;
    logic        bus_we;
    logic [3:0]  bus_addr;
    logic [3:0]  bus_be;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        irq;

    int vectors     = 0;
    int miscompares = 0;
    int irq_cnt     = 0;
    int run_len     = 0;
    int max_run     = 0;
    bit done        = 0;

    always #10 clk = ~clk;

    gated_gpi #(.NUM_PINS(PINS), .SYNC_STAGES(2), .ADDR_W(4)) i_gated_gpi (
        .clk         (clk),
        .rst_n       (rst_n),
        .gpi_pins_i  (pins),
        .gpi_en_i    (en),
        .bus_en_i    (bus_en),
        .bus_we_i    (bus_we),
        .bus_addr_i  (bus_addr),
        .bus_be_i    (bus_be),
        .bus_wdata_i (bus_wdata),
        .bus_rdata_o (bus_rdata),
        .irq_o       (irq)
    );

    // Count interrupt cycles and the longest run of consecutive high cycles.
    always @(posedge clk) begin
        if (rst_n && irq) begin
            irq_cnt <= irq_cnt + 1;
            run_len <= run_len + 1;
            if (run_len + 1 > max_run) max_run <= run_len + 1;
        end else begin
            run_len <= 0;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_read(input logic [3:0] addr, input logic [3:0] be, output logic [31:0] data);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = addr; bus_be = be;
        @(negedge clk);
        data = bus_rdata;
        bus_en = 1'b0; bus_addr = '0; bus_be = '0;
    endtask

    task automatic do_write(input logic [31:0] data);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = '0; bus_be = 4'hF; bus_wdata = data;
        @(negedge clk);
        chk("R8 rdata during write", bus_rdata, 32'h0);
        bus_en = 1'b0; bus_we = 1'b0; bus_be = '0; bus_wdata = '0;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        idle(3);
        chk("R1 irq in reset", {31'b0, irq}, 32'h0);
        chk("R1 rdata in reset", bus_rdata, 32'h0);
        rst_n = 1'b1;
        idle(4);
        do_read(4'h0, 4'hF, d);
        chk("R1 read after reset", d, 32'h0);
    endtask

    task automatic t_follow;
        logic [31:0] d;
        en = 32'hFFFF_FFFF;
        pins = 32'h00A5_C35A;
        idle(4);
        do_read(4'h0, 4'hF, d);
        chk("R2 pattern A", d, 32'h00A5_C35A);
        pins = 32'h005A_3CA5;
        idle(4);
        do_read(4'h0, 4'hF, d);
        chk("R2 pattern B", d, 32'h005A_3CA5);
    endtask

    task automatic t_irq_timing;
        pins = 32'h0;
        idle(5);
        pins = 32'h1;
        @(negedge clk); chk("R5 irq after edge 1", {31'b0, irq}, 32'h0);
        @(negedge clk); chk("R5 irq after edge 2", {31'b0, irq}, 32'h0);
        @(negedge clk); chk("R5 irq after edge 3", {31'b0, irq}, 32'h1);
        @(negedge clk); chk("R5 irq after edge 4", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_disabled;
        logic [31:0] d;
        int base;
        pins = 32'h0;
        en = 32'h0000_00FF;
        idle(5);
        base = irq_cnt;
        pins = 32'hFFFF_FFFF;
        idle(6);
        do_read(4'h0, 4'hF, d);
        chk("R3 only enabled pins stored", d, 32'h0000_00FF);
        chk("R7 eight bits rise together, one pulse", irq_cnt - base, 32'd1);
        base = irq_cnt;
        pins = 32'h0000_00FF;
        idle(3);
        pins = 32'hFFFF_00FF;
        idle(6);
        chk("R3 disabled toggles raise no irq", irq_cnt - base, 32'd0);
        do_read(4'h0, 4'hF, d);
        chk("R3 disabled toggles not stored", d, 32'h0000_00FF);
    endtask

    task automatic t_mask_clear;
        logic [31:0] d;
        int base;
        en = 32'hFFFF_FFFF;
        pins = 32'hFFFF_FFFF;
        idle(6);
        do_read(4'h0, 4'hF, d);
        chk("R2 all enabled high", d, VMASK);
        base = irq_cnt;
        en = 32'h00F0_0F00;
        idle(1);
        do_read(4'h0, 4'hF, d);
        chk("R4 dropped enables clear at once", d, 32'h00F0_0F00);
        idle(3);
        chk("R4 clearing raises no irq", irq_cnt - base, 32'd0);
    endtask

    task automatic t_reenable;
        logic [31:0] d;
        int base;
        base = irq_cnt;
        en = 32'hFFFF_FFFF;
        idle(4);
        chk("R5 re-enabling high pins pulses once", irq_cnt - base, 32'd1);
        do_read(4'h0, 4'hF, d);
        chk("R5 re-enabled pins stored", d, VMASK);
    endtask

    task automatic t_fall;
        logic [31:0] d;
        int base;
        base = irq_cnt;
        pins = 32'h0;
        idle(6);
        chk("R6 falling raises no irq", irq_cnt - base, 32'd0);
        do_read(4'h0, 4'hF, d);
        chk("R6 stored after fall", d, 32'h0);
    endtask

    task automatic t_multi;
        logic [31:0] d;
        int base;
        base = irq_cnt;
        pins = 32'h0012_3456;
        idle(6);
        chk("R7 simultaneous rises one pulse", irq_cnt - base, 32'd1);
        chk("R7 pulse width", max_run, 32'd1);
        do_read(4'h0, 4'hF, d);
        chk("R2 pattern C", d, 32'h0012_3456);
    endtask

    task automatic t_write;
        logic [31:0] d;
        do_write(32'hFFFF_FFFF);
        do_read(4'h0, 4'hF, d);
        chk("R8 write of ones ignored", d, 32'h0012_3456);
        do_write(32'h0);
        do_read(4'h0, 4'hF, d);
        chk("R8 write of zeros ignored", d, 32'h0012_3456);
    endtask

    task automatic t_access;
        logic [31:0] d;
        int base;
        do_read(4'h4, 4'hF, d);
        chk("R9 other offset reads 0", d, 32'h0);
        do_read(4'h0, 4'h3, d);
        chk("R9 partial byte enables read 0", d, 32'h0);
        base = irq_cnt;
        pins = 32'hFF12_3456;
        idle(6);
        do_read(4'h0, 4'hF, d);
        chk("R9 pins above count invisible", d, 32'h0012_3456);
        chk("R9 pins above count raise no irq", irq_cnt - base, 32'd0);
    endtask

    initial begin
        rst_n = 1'b0; pins = '0; en = '0;
        bus_en = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_be = '0; bus_wdata = '0;
        @(negedge clk);
        t_reset();
        t_follow();
        t_irq_timing();
        t_disabled();
        t_mask_clear();
        t_reenable();
        t_fall();
        t_multi();
        t_write();
        t_access();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            vectors++;
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule